// File: doc/BRIEF.md
# Self-Routing Butterfly Switch Fabric

This block is a multistage interconnect built from 2x2 switching elements arranged as a butterfly. It joins 2^A sources to 2^A destinations, where A is the address width parameter. The fabric has A switch stages, one between each pair of neighbouring columns of rows. Each source may offer one packet per transfer: a valid bit, a destination row and a payload. No central controller is involved. Each packet carries a routing tag, formed as the bitwise XOR of its own row number and its destination. Stage s reads tag bit s. A 1 turns the switch to cross and a 0 keeps it straight. Stage 0 fixes address bit 0 and the last stage fixes the top bit.

The fabric is not a permutation network. When two live packets enter the same switch and both want the same output, the packet from the lower-numbered row of that switch keeps its path. The other packet is discarded, its source is flagged as blocked, and the stage raises its conflict flag. A parameter places a register after every stage; without it the fabric is purely combinational. Blocked and conflict indications travel with the data, so they line up with the outputs they explain.

Top module: `bfly_fabric`

## Requirements
- R1: A valid packet from source row i to destination d that is not blocked appears at output row d with out_valid[d]=1, its payload on out_data slice d and i on out_src slice d.
- R2: The tag is i XOR d. Stage s (s=0 first) moves a packet from row r to row r XOR 2^s when tag bit s is 1 and leaves it on row r when that bit is 0.
- R3: out_conflict[s] is 1 exactly when, in stage s, some switch holds two live packets that want the same output row.
- R4: In a stage-s clash, the packet on the lower row of the pair (address bit s = 0) wins. The other packet is dropped from every later stage and out_blocked[source] becomes 1.
- R5: An input with in_valid low drives no output and takes no part in conflict detection, whatever its destination.
- R6: An output row that receives no packet shows out_valid=0 with all-zero payload and source fields.
- R7: Packing permutations (the k-th valid source in row order sent to destination k) and the identity route with out_conflict all zero.
- R8: The bit-reversal permutation for A=3 produces at least one conflict.
- R9: With REG_STAGES=1 the outputs follow the inputs after exactly A rising edges. With REG_STAGES=0 they follow in the same cycle. While rst_n is low, all registered outputs read zero.
- R10: The number of delivered packets plus the number of blocked sources equals the number of valid inputs, and only valid sources are ever flagged blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional stage registers |
| rst_n | input | 1 | Active-low synchronous reset of the stage registers |
| in_valid | input | 2^A | Per-source packet present |
| in_dest | input | 2^A*A | Per-source destination row, slice i for source i |
| in_data | input | 2^A*W | Per-source payload |
| out_valid | output | 2^A | Per-destination packet delivered |
| out_data | output | 2^A*W | Payload delivered to each destination |
| out_src | output | 2^A*A | Source row of each delivered packet |
| out_blocked | output | 2^A | Per-source: packet lost in a clash |
| out_conflict | output | A | Per-stage clash flag, bit s for stage s |

## Verification
The hardest case to reach from the ports is a clash in a late stage whose loser has already crossed in earlier stages. The clash must also not be hidden by an earlier clash that removed one of the two packets. Directed patterns set up clashes in stage 0 alone and in the last stage alone. They also repeat a clash with one party's valid bit low. The bit-reversal and random many-source patterns then produce chains of clashes across stages, where the winner and loser both depend on rows reached after crossing. A bench model that tracks each packet's row stage by stage predicts every field.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
   // packet word layout: valid | tag | source | payload (LSB first)
   function automatic int pkt_w(int a, int w);
      return 1 + 2 * a + w;
   endfunction
   function automatic int tag_lsb();
      return 1;
   endfunction
   function automatic int src_lsb(int a);
      return 1 + a;
   endfunction
   function automatic int dat_lsb(int a);
      return 1 + 2 * a;
   endfunction
endpackage

// File: rtl/bfly_switch.sv
module bfly_switch
   import bfly_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8,
   parameter int STAGE  = 0
) (
   input  logic [pkt_w(ADDR_W, DATA_W)-1:0] lo_i,
   input  logic [pkt_w(ADDR_W, DATA_W)-1:0] hi_i,
   output logic [pkt_w(ADDR_W, DATA_W)-1:0] lo_o,
   output logic [pkt_w(ADDR_W, DATA_W)-1:0] hi_o,
   output logic                             clash_o,
   output logic [ADDR_W-1:0]                loser_o
);
   localparam int TB = tag_lsb() + STAGE;
   localparam int SB = src_lsb(ADDR_W);

   logic va, vb, ta, tb, b_live;

   always_comb begin
      va      = lo_i[0];
      vb      = hi_i[0];
      ta      = lo_i[TB];
      tb      = hi_i[TB];
      // upper packet wants the lower row when it crosses, lower packet when straight
      clash_o = va & vb & (ta ^ tb);
      b_live  = vb & ~clash_o;
      loser_o = hi_i[SB +: ADDR_W];
      lo_o    = '0;
      hi_o    = '0;
      if (va & ~ta)          lo_o = lo_i;
      else if (b_live & tb)  lo_o = hi_i;
      if (va & ta)           hi_o = lo_i;
      else if (b_live & ~tb) hi_o = hi_i;
   end
endmodule

// File: rtl/bfly_stage.sv
module bfly_stage
   import bfly_pkg::*;
#(
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 8,
   parameter int STAGE      = 0,
   parameter bit REG_STAGES = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [(2**ADDR_W)*pkt_w(ADDR_W,DATA_W)-1:0] pkt_i,
   input  logic [(2**ADDR_W)-1:0]                  blk_i,
   input  logic [ADDR_W-1:0]                       cfl_i,
   output logic [(2**ADDR_W)*pkt_w(ADDR_W,DATA_W)-1:0] pkt_o,
   output logic [(2**ADDR_W)-1:0]                  blk_o,
   output logic [ADDR_W-1:0]                       cfl_o
);
   localparam int N    = 2 ** ADDR_W;
   localparam int PW   = pkt_w(ADDR_W, DATA_W);
   localparam int HALF = N / 2;
   localparam int LOWM = (1 << STAGE) - 1;

   logic [N*PW-1:0]    pkt_n;
   logic [N-1:0]       blk_n;
   logic [ADDR_W-1:0]  cfl_n;
   logic [HALF-1:0]    clash;
   logic [ADDR_W-1:0]  loser [HALF];

   for (genvar k = 0; k < HALF; k++) begin : g_sw
      // lower row of pair k: bit STAGE forced to 0, other bits taken from k
      localparam int LO = ((k >> STAGE) << (STAGE + 1)) | (k & LOWM);
      localparam int HI = LO | (1 << STAGE);
      bfly_switch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGE(STAGE)) u_sw (
         .lo_i    (pkt_i[LO*PW +: PW]),
         .hi_i    (pkt_i[HI*PW +: PW]),
         .lo_o    (pkt_n[LO*PW +: PW]),
         .hi_o    (pkt_n[HI*PW +: PW]),
         .clash_o (clash[k]),
         .loser_o (loser[k])
      );
   end

   always_comb begin
      blk_n = blk_i;
      for (int k = 0; k < HALF; k++)
         if (clash[k]) blk_n[loser[k]] = 1'b1;
      cfl_n        = cfl_i;
      cfl_n[STAGE] = |clash;
   end

   if (REG_STAGES) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pkt_o <= '0;
            blk_o <= '0;
            cfl_o <= '0;
         end else begin
            pkt_o <= pkt_n;
            blk_o <= blk_n;
            cfl_o <= cfl_n;
         end
      end
   end else begin : g_comb
      assign pkt_o = pkt_n;
      assign blk_o = blk_n;
      assign cfl_o = cfl_n;
   end
endmodule

// File: rtl/bfly_fabric.sv
module bfly_fabric
   import bfly_pkg::*;
#(
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 8,
   parameter bit REG_STAGES = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [(2**ADDR_W)-1:0]        in_valid,
   input  logic [(2**ADDR_W)*ADDR_W-1:0] in_dest,
   input  logic [(2**ADDR_W)*DATA_W-1:0] in_data,
   output logic [(2**ADDR_W)-1:0]        out_valid,
   output logic [(2**ADDR_W)*DATA_W-1:0] out_data,
   output logic [(2**ADDR_W)*ADDR_W-1:0] out_src,
   output logic [(2**ADDR_W)-1:0]        out_blocked,
   output logic [ADDR_W-1:0]            out_conflict
);
   localparam int N  = 2 ** ADDR_W;
   localparam int PW = pkt_w(ADDR_W, DATA_W);
   localparam int SB = src_lsb(ADDR_W);
   localparam int DB = dat_lsb(ADDR_W);

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("bfly_fabric: ADDR_W must lie in 1..8");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("bfly_fabric: DATA_W must be positive");
   end

   logic [N*PW-1:0]   pk [ADDR_W+1];
   logic [N-1:0]      bl [ADDR_W+1];
   logic [ADDR_W-1:0] cf [ADDR_W+1];

   for (genvar r = 0; r < N; r++) begin : g_inj
      localparam logic [ADDR_W-1:0] RID = ADDR_W'(r);
      assign pk[0][r*PW +: PW] = in_valid[r] ?
         {in_data[r*DATA_W +: DATA_W], RID, in_dest[r*ADDR_W +: ADDR_W] ^ RID, 1'b1} : '0;
   end
   assign bl[0] = '0;
   assign cf[0] = '0;

   for (genvar s = 0; s < ADDR_W; s++) begin : g_stg
      bfly_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGE(s), .REG_STAGES(REG_STAGES)) u_stg (
         .clk   (clk),
         .rst_n (rst_n),
         .pkt_i (pk[s]),
         .blk_i (bl[s]),
         .cfl_i (cf[s]),
         .pkt_o (pk[s+1]),
         .blk_o (bl[s+1]),
         .cfl_o (cf[s+1])
      );
   end

   for (genvar r = 0; r < N; r++) begin : g_out
      assign out_valid[r]                 = pk[ADDR_W][r*PW];
      assign out_src[r*ADDR_W +: ADDR_W]  = pk[ADDR_W][r*PW + SB +: ADDR_W];
      assign out_data[r*DATA_W +: DATA_W] = pk[ADDR_W][r*PW + DB +: DATA_W];
   end
   assign out_blocked  = bl[ADDR_W];
   assign out_conflict = cf[ADDR_W];
endmodule

// File: rtl/bfly_fabric_chk.sv
module bfly_fabric_chk #(
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 8,
   parameter bit REG_STAGES = 1'b1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [(2**ADDR_W)-1:0]        in_valid,
   input logic [(2**ADDR_W)*ADDR_W-1:0] in_dest,
   input logic [(2**ADDR_W)-1:0]        out_valid,
   input logic [(2**ADDR_W)*DATA_W-1:0] out_data,
   input logic [(2**ADDR_W)*ADDR_W-1:0] out_src,
   input logic [(2**ADDR_W)-1:0]        out_blocked,
   input logic [ADDR_W-1:0]            out_conflict
);
   localparam int N   = 2 ** ADDR_W;
   localparam int LAT = REG_STAGES ? ADDR_W : 0;

   // input history aligned with the fabric latency
   logic [N-1:0]        hv [LAT+1];
   logic [N*ADDR_W-1:0] hd [LAT+1];
   assign hv[0] = in_valid;
   assign hd[0] = in_dest;
   for (genvar i = 1; i <= LAT; i++) begin : g_hist
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hv[i] <= '0;
            hd[i] <= '0;
         end else begin
            hv[i] <= hv[i-1];
            hd[i] <= hd[i-1];
         end
      end
   end

   // R10: every valid packet is either delivered or blocked
   p_conserve_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(out_valid) + $countones(out_blocked)) == $countones(hv[LAT]));

   // R10: only a valid source can be blocked
   p_blk_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_blocked & ~hv[LAT]) == '0);

   // R3, R4: a loss happens exactly when some stage clashed
   p_cfl_blk_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_conflict != '0) == (out_blocked != '0));

   for (genvar r = 0; r < N; r++) begin : g_row
      logic [ADDR_W-1:0] sid;
      logic [ADDR_W-1:0] want;
      assign sid  = out_src[r*ADDR_W +: ADDR_W];
      assign want = hd[LAT][sid*ADDR_W +: ADDR_W];

      // R1: a delivered packet sits on its own destination row
      p_dest_r1: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[r] |-> (want == ADDR_W'(r)) && hv[LAT][sid] && !out_blocked[sid]);

      // R6: empty rows carry zero fields
      p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid[r] |-> (out_data[r*DATA_W +: DATA_W] == '0) && (sid == '0));
   end
endmodule

bind bfly_fabric bfly_fabric_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_STAGES(REG_STAGES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_dest      (in_dest),
   .out_valid    (out_valid),
   .out_data     (out_data),
   .out_src      (out_src),
   .out_blocked  (out_blocked),
   .out_conflict (out_conflict)
);

// File: tb/sim_bfly_fabric.sv
module sim_bfly_fabric;
   localparam int  A      = 3;
   localparam int  W      = 8;
   localparam int  N      = 2 ** A;
   localparam bit  PIPE   = 1'b1;
   localparam int  LAT    = PIPE ? A : 0;
   localparam time CLK_PERIOD = 10ns;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   in_valid = '0;
   logic [N*A-1:0] in_dest = '0;
   logic [N*W-1:0] in_data = '0;
   logic [N-1:0]   out_valid;
   logic [N*W-1:0] out_data;
   logic [N*A-1:0] out_src;
   logic [N-1:0]   out_blocked;
   logic [A-1:0]   out_conflict;

   int n_chk = 0;
   int n_err = 0;

   logic [N-1:0]   e_valid;
   logic [N*W-1:0] e_data;
   logic [N*A-1:0] e_src;
   logic [N-1:0]   e_blk;
   logic [A-1:0]   e_cfl;

   always #(CLK_PERIOD/2) clk = ~clk;

   bfly_fabric #(.ADDR_W(A), .DATA_W(W), .REG_STAGES(PIPE)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
      .out_src(out_src), .out_blocked(out_blocked), .out_conflict(out_conflict)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // model: follow each packet row by row; on a shared next row the packet
   // currently on the lower row keeps going
   task automatic model();
      int pos [N];
      int nxt [N];
      bit alive [N];
      e_valid = '0; e_data = '0; e_src = '0; e_blk = '0; e_cfl = '0;
      for (int i = 0; i < N; i++) begin
         pos[i]   = i;
         alive[i] = in_valid[i];
      end
      for (int s = 0; s < A; s++) begin
         for (int i = 0; i < N; i++) begin
            int tag;
            tag    = i ^ int'(in_dest[i*A +: A]);
            nxt[i] = ((tag >> s) & 1) ? (pos[i] ^ (1 << s)) : pos[i];
         end
         for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
               if (alive[i] && alive[j] && nxt[i] == nxt[j]) begin
                  e_cfl[s] = 1'b1;
                  if (pos[i] < pos[j]) begin alive[j] = 0; e_blk[j] = 1'b1; end
                  else                 begin alive[i] = 0; e_blk[i] = 1'b1; end
               end
         for (int i = 0; i < N; i++) pos[i] = nxt[i];
      end
      for (int i = 0; i < N; i++)
         if (alive[i]) begin
            e_valid[pos[i]]           = 1'b1;
            e_data[pos[i]*W +: W]     = in_data[i*W +: W];
            e_src[pos[i]*A +: A]      = A'(i);
         end
   endtask

   task automatic run(string what);
      model();
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk({"R1 valid ", what}, 64'(out_valid), 64'(e_valid));
      chk({"R1 R6 data ", what}, 64'(out_data), 64'(e_data));
      chk({"R1 R6 src ", what}, 64'(out_src), 64'(e_src));
      chk({"R4 blocked ", what}, 64'(out_blocked), 64'(e_blk));
      chk({"R3 conflict ", what}, 64'(out_conflict), 64'(e_cfl));
   endtask

   task automatic load(logic [N-1:0] v, logic [N*A-1:0] d);
      in_valid = v;
      in_dest  = d;
      for (int i = 0; i < N; i++) in_data[i*W +: W] = W'(8'hA0 + i * 7);
   endtask

   function automatic logic [N*A-1:0] perm(int kind);
      logic [N*A-1:0] d;
      for (int i = 0; i < N; i++)
         case (kind)
            0: d[i*A +: A] = A'(i);
            default: d[i*A +: A] = {<<{A'(i)}};
         endcase
      return d;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [N*A-1:0] d;
      void'($urandom(32'h1234_5eed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset holds outputs at zero
      chk("R9 reset valid", 64'(out_valid), 64'h0);
      chk("R9 reset flags", 64'({out_blocked, out_conflict}), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R9: single packet 3 -> 6 appears only after LAT edges
      d = '0; d[3*A +: A] = 3'd6;
      load(8'b0000_1000, d);
      model();
      if (LAT > 0) begin
         repeat (LAT - 1) @(posedge clk);
         @(negedge clk);
         chk("R9 before latency", 64'(out_valid), 64'h0);
         @(posedge clk);
         @(negedge clk);
      end else @(negedge clk);
      chk("R9 R2 arrival row 6", 64'(out_valid), 64'h40);
      run("3to6");

      // R2: 6 -> 1 all crossings
      d = '0; d[6*A +: A] = 3'd1;
      load(8'b0100_0000, d); run("R2 6to1");

      // R3 R4: stage-0 clash, sources 0 and 1 both to row 0
      d = '0; d[1*A +: A] = 3'd0;
      load(8'b0000_0011, d); run("R3 stage0 clash");
      chk("R4 src1 loses", 64'(out_blocked), 64'h02);
      chk("R3 stage0 flag", 64'(out_conflict), 64'h1);

      // R3: last-stage clash, sources 0 and 4 both to row 0
      d = '0;
      load(8'b0001_0001, d); run("R3 stage2 clash");
      chk("R3 stage2 flag", 64'(out_conflict), 64'h4);

      // R5: the same pair with source 4 invalid
      load(8'b0000_0001, d); run("R5 invalid ignored");
      chk("R5 no conflict", 64'(out_conflict), 64'h0);
      chk("R5 only row0", 64'(out_valid), 64'h01);

      // R7: identity and packing
      load('1, perm(0)); run("R7 identity");
      chk("R7 identity clean", 64'(out_conflict), 64'h0);
      d = '0; d[1*A +: A] = 3'd0; d[3*A +: A] = 3'd1; d[4*A +: A] = 3'd2; d[6*A +: A] = 3'd3;
      load(8'b0101_1010, d); run("R7 packing");
      chk("R7 packing clean", 64'(out_conflict), 64'h0);

      // R8: bit reversal collides
      load('1, perm(1)); run("R8 bitrev");
      chk("R8 bitrev conflicts", 64'(out_conflict != '0), 64'h1);

      // random traffic, R10 conservation checked in every pattern
      for (int t = 0; t < 60; t++) begin
         d = '0;
         for (int i = 0; i < N; i++) d[i*A +: A] = A'($urandom_range(N - 1));
         load(N'($urandom), d);
         for (int i = 0; i < N; i++) in_data[i*W +: W] = W'($urandom);
         run("random");
         chk("R10 conservation", 64'($countones(out_valid) + $countones(out_blocked)),
             64'($countones(in_valid)));
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule